// File: doc/BRIEF.md
# PHY Management Frame Controller

This block lets a host read and write registers of an Ethernet PHY over the two-wire management interface: a clock it drives (MDC) and a bidirectional data line (MDIO). The host packs a whole transaction into one 32-bit command/status word in a single store. That word holds the opcode bits, the PHY address, the register address and the write data. The block then serialises a clause-22 management frame, with each MDC half period taken from a parameterised divider.

When the frame ends, the block raises a ready flag in the same word. For a read, the 16-bit data field then holds the value the PHY returned. If the command enabled it, completion also latches an event bit in a separate 16-bit status word. That bit stays set until software acknowledges it.

MDIO is presented as an output value plus an output-enable, with a separate input. The pad and any tri-state buffering belong to the surrounding chip.

Top module: `mdio_mgmt_top`

## Requirements
- R1: Command word layout, both when written and when read back. Bits 15:0 hold the data. Bits 20:16 hold the register address and bits 25:21 the PHY address. Bit 26 requests a write and bit 27 a read. Bit 28 is ready and bit 29 is the completion-interrupt enable. Bits 31:30 read as zero. When a read frame finishes, bits 15:0 take the value captured from the PHY. A write leaves them unchanged.
- R2: A store with bit 26 or bit 27 set, made while no frame runs, does three things at the next clock edge: it updates all fields, clears ready and starts a frame. If both bits are set, the frame is a read. Ready stays low for as long as the frame runs.
- R3: The frame is 64 bits, sent MSB first in this order: 32 ones; start bits 0,1; opcode 1,0 for a read or 0,1 for a write; 5 PHY address bits; 5 register address bits; 2 turnaround bits; 16 data bits. In a write, the turnaround is driven as 1,0 and the data bits are bits 15:0 of the command.
- R4: A read frame stops driving MDIO (enable low) from turnaround bit 46 to bit 63. On the rising MDC edge of each of bits 48 to 63, it samples the input MDIO. The first sampled bit becomes bit 15 of the result.
- R5: Each MDC half period lasts exactly MDC_HALF clock cycles, and a frame has 64 rising edges. MDC rests low between frames. MDIO and its enable change only after a falling MDC edge, never at a rising one.
- R6: Ready rises exactly 128*MDC_HALF clock cycles after the edge that accepts the command. The default MDC_HALF of 50 at a 250 MHz clock gives 2.5 MHz MDC and a 25.6 µs frame, well inside a 64 µs host polling limit.
- R7: A command store made while a frame runs is ignored. No field changes, and the running frame goes on unaltered.
- R8: When a frame finishes and bit 29 of the accepted command was set, bit 11 of the status word becomes 1. If bit 29 was clear, bit 11 stays 0. All other status bits read 0.
- R9: Status bit 11 holds until an acknowledge store with bit 11 set clears it. An acknowledge store with bit 11 clear has no effect.
- R10: After reset, the command word and the status word are zero, and MDC and the MDIO enable are low.
- R11: A store with bits 26 and 27 both clear, made while idle, updates the data, address and enable fields, leaves ready unchanged, and produces no MDC activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Store strobe for the command word |
| cmdWrData | input | 32 | Command word value being stored |
| cmdRdData | output | 32 | Current command/status word |
| ackWrEn | input | 1 | Store strobe for the status acknowledge |
| ackWrData | input | 16 | Acknowledge value; a 1 in bit 11 clears the completion bit |
| statusWord | output | 16 | Event status; bit 11 is frame completion |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value while driven |
| mdioOe | output | 1 | MDIO drive enable |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
The assertions check on every cycle the rules that need no record of the frame's contents:
- each MDC level is held for at least the programmed half period;
- MDC rests low when idle;
- MDIO and its enable stay steady across a rising MDC edge;
- ready stays low while a frame runs;
- a store during a frame leaves the fields untouched;
- the completion bit rises only with ready and an enabled interrupt, and it persists until acknowledged.

Only the bench scenarios can show the bit-exact frame contents, the read data assembled from the PHY's bits, the exact ready latency, and the acknowledge and no-opcode behaviour. The bench checks these with a PHY model that captures every rising edge, across all 32 PHY addresses in both directions.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;   // first turnaround bit
  localparam int DATA_POS   = 48;   // first data bit
  localparam int DATA_W     = 16;
  localparam int STAT_DONE  = 11;

  typedef struct packed {
    logic load;      // accept command, build frame
    logic shift;     // falling MDC: advance to next bit
    logic sample;    // rising MDC inside data field
    logic finish;    // falling MDC after last bit
    logic busy;      // frame in progress
    logic driveAll;  // bit index before turnaround
  } mgmtStrobe_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic        opReq,
  output mgmtStrobe_t strobe,
  output logic        mdc
);
  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic             busy;
  logic             mdcR;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             tick;
  logic             start;
  logic             lastBit;

  assign tick    = busy && (divCnt == DIV_W'(MDC_HALF - 1));
  assign start   = cmdWrEn && opReq && !busy;
  assign lastBit = (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdcR   <= ~mdcR;
        if (mdcR) begin
          if (lastBit) busy <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load     = start;
    strobe.shift    = tick && mdcR && !lastBit;
    strobe.sample   = tick && !mdcR && (bitCnt >= CNT_W'(DATA_POS));
    strobe.finish   = tick && mdcR && lastBit;
    strobe.busy     = busy;
    strobe.driveAll = busy && (bitCnt < CNT_W'(TA_POS));
  end

  assign mdc = mdcR;
endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mgmtStrobe_t strobe,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  input  logic        ackWrEn,
  input  logic [15:0] ackWrData,
  input  logic        mdioIn,
  output logic        opReq,
  output logic [31:0] cmdRdData,
  output logic [15:0] statusWord,
  output logic        mdioOut,
  output logic        mdioOe
);
  logic [DATA_W-1:0]     dataF;
  logic [4:0]            regF;
  logic [4:0]            phyF;
  logic                  wrF, rdF, readyF, ieF;
  logic                  frameRead;
  logic [FRAME_BITS-1:0] shiftR;
  logic [DATA_W-1:0]     rdShift;
  logic                  doneStat;
  logic                  unusedBits;

  assign unusedBits = ^{cmdWrData[31:30], cmdWrData[28],
                        ackWrData[15:STAT_DONE+1], ackWrData[STAT_DONE-1:0]};

  assign opReq = cmdWrData[26] | cmdWrData[27];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataF     <= '0;
      regF      <= '0;
      phyF      <= '0;
      wrF       <= 1'b0;
      rdF       <= 1'b0;
      readyF    <= 1'b0;
      ieF       <= 1'b0;
      frameRead <= 1'b0;
      shiftR    <= '0;
      rdShift   <= '0;
      doneStat  <= 1'b0;
    end else begin
      if (cmdWrEn && !strobe.busy) begin
        dataF <= cmdWrData[15:0];
        regF  <= cmdWrData[20:16];
        phyF  <= cmdWrData[25:21];
        wrF   <= cmdWrData[26];
        rdF   <= cmdWrData[27];
        ieF   <= cmdWrData[29];
        if (opReq) readyF <= 1'b0;
      end
      if (strobe.load) begin
        frameRead <= cmdWrData[27];
        shiftR    <= {32'hFFFF_FFFF, 2'b01,
                      cmdWrData[27] ? 2'b10 : 2'b01,
                      cmdWrData[25:21], cmdWrData[20:16],
                      cmdWrData[27] ? 2'b11 : 2'b10,
                      cmdWrData[15:0]};
      end else if (strobe.shift) begin
        shiftR <= {shiftR[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.sample && frameRead)
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (strobe.finish) begin
        readyF <= 1'b1;
        if (frameRead) dataF <= rdShift;
      end
      if (strobe.finish && ieF)
        doneStat <= 1'b1;
      else if (ackWrEn && ackWrData[STAT_DONE])
        doneStat <= 1'b0;
    end
  end

  assign mdioOut    = shiftR[FRAME_BITS-1];
  assign mdioOe     = strobe.driveAll || (strobe.busy && !frameRead);
  assign cmdRdData  = {2'b00, ieF, readyF, rdF, wrF, phyF, regF, dataF};
  assign statusWord = {4'b0000, doneStat, 11'b0};
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  input  logic        ackWrEn,
  input  logic [15:0] ackWrData,
  output logic [15:0] statusWord,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mgmtStrobe_t strobe;
  logic        opReq;
  logic        busyMon;

  assign busyMon = strobe.busy;

  mdio_mgmt_ctrl #(.MDC_HALF(MDC_HALF)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWrEn (cmdWrEn),
    .opReq   (opReq),
    .strobe  (strobe),
    .mdc     (mdc)
  );

  mdio_mgmt_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdWrEn    (cmdWrEn),
    .cmdWrData  (cmdWrData),
    .ackWrEn    (ackWrEn),
    .ackWrData  (ackWrData),
    .mdioIn     (mdioIn),
    .opReq      (opReq),
    .cmdRdData  (cmdRdData),
    .statusWord (statusWord),
    .mdioOut    (mdioOut),
    .mdioOe     (mdioOe)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int MDC_HALF = 50
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        cmdWrEn,
  input logic        ackWrEn,
  input logic [15:0] ackWrData,
  input logic [31:0] cmdRdData,
  input logic [15:0] statusWord,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  localparam int GAP_W = $clog2(MDC_HALF + 2) + 1;

  logic             mdcQ;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcQ <= 1'b0;
      gap  <= '0;
    end else begin
      mdcQ <= mdc;
      if (mdc != mdcQ)  gap <= GAP_W'(1);
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  // R5: every MDC level is held for at least MDC_HALF cycles
  a_r5_mdc_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (mdc != mdcQ) |-> (gap >= GAP_W'(MDC_HALF)));

  a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  a_r5_mdio_steady_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe)));

  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdRdData[28]);

  a_r7_busy_store_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn) |=> $stable(cmdRdData[29:16]));

  a_r4_release_only_read: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !mdioOe) |-> cmdRdData[27]);

  a_r8_done_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[11]) |-> (cmdRdData[29] && $rose(cmdRdData[28])));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[11] && !(ackWrEn && ackWrData[11])) |=> statusWord[11]);
endmodule

bind mdio_mgmt_top mdio_mgmt_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busyMon),
  .cmdWrEn    (cmdWrEn),
  .ackWrEn    (ackWrEn),
  .ackWrData  (ackWrData),
  .cmdRdData  (cmdRdData),
  .statusWord (statusWord),
  .mdc        (mdc),
  .mdioOut    (mdioOut),
  .mdioOe     (mdioOe)
);

// File: tb/mdio_mgmt_top_tb.sv
module mdio_mgmt_top_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic        ackWrEn = 1'b0;
  logic [15:0] ackWrData = '0;
  logic [15:0] statusWord;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int vecs = 0;
  int errs = 0;

  logic [63:0] gotBits = '0;
  logic [63:0] gotOe = '0;
  int          edgeCnt = 0;
  logic [15:0] phyRdVal = '0;

  always #2 clk = ~clk;

  mdio_mgmt_top #(.MDC_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .ackWrEn(ackWrEn), .ackWrData(ackWrData),
    .statusWord(statusWord), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn));

  // PHY model: capture on rising MDC, present next read bit after falling MDC
  always @(posedge mdc) begin
    gotBits <= {gotBits[62:0], mdioOut};
    gotOe   <= {gotOe[62:0], mdioOe};
    edgeCnt <= edgeCnt + 1;
  end

  function automatic logic phyBit(int idx);
    if (idx >= 48 && idx < 64) return phyRdVal[63 - idx];
    return 1'b1;
  endfunction

  always @(negedge mdc) mdioIn = phyBit(edgeCnt);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runTxn(logic isRd, logic [4:0] phy, logic [4:0] rg,
                        logic [15:0] data, logic ie, logic mid, logic both);
    logic [31:0] cmd;
    logic [63:0] expFrame, expOe;
    int cycles;
    phyRdVal = 16'(phy * 16'h0421) ^ 16'(rg * 16'h1111) ^ 16'h5A3C;
    edgeCnt = 0;
    mdioIn = 1'b1;
    cmd = {2'b00, ie, 1'b0, isRd, (!isRd) | both, phy, rg, data};
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = cmd;
    @(negedge clk); cmdWrEn = 1'b0;
    check("R2 ready cleared on start", 64'(cmdRdData[28]), 64'd0);
    cycles = 0;
    while (!cmdRdData[28] && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      cmdWrEn = mid && (cycles == 40);
      if (cycles == 40) cmdWrData = cmd ^ 32'h2BFF_FFFF;
    end
    check("R6 ready latency", 64'(cycles), 64'(128 * HALF));
    expFrame = {32'hFFFF_FFFF, 2'b01, isRd ? 2'b10 : 2'b01, phy, rg,
                isRd ? 2'b00 : 2'b10, isRd ? 16'h0 : data};
    expOe = isRd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    check(mid ? "R3 R7 frame bits" : "R3 frame bits", gotBits & expOe, expFrame & expOe);
    check("R4 drive enable pattern", gotOe, expOe);
    check("R5 rising edge count", 64'(edgeCnt), 64'd64);
    check(mid ? "R1 R7 readback" : (both ? "R1 R2 readback" : "R1 readback"),
          64'(cmdRdData),
          64'({2'b00, ie, 1'b1, isRd, (!isRd) | both, phy, rg,
               isRd ? phyRdVal : data}));
    check("R8 completion status", 64'(statusWord), 64'({4'b0, ie, 11'b0}));
    @(negedge clk); ackWrEn = 1'b1; ackWrData = 16'hF7FF;
    @(negedge clk); ackWrEn = 1'b0;
    check("R9 ack without bit 11 ignored", 64'(statusWord[11]), 64'(ie));
    @(negedge clk); ackWrEn = 1'b1; ackWrData = 16'h0800;
    @(negedge clk); ackWrEn = 1'b0;
    check("R9 ack clears", 64'(statusWord), 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset command word", 64'(cmdRdData), 64'd0);
    check("R10 reset status/mdc/oe", 64'({statusWord, mdc, mdioOe}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: no-opcode store while idle
    edgeCnt = 0;
    cmdWrEn = 1'b1; cmdWrData = 32'h20AB_1234;
    @(negedge clk); cmdWrEn = 1'b0;
    repeat (20) @(negedge clk);
    check("R11 fields stored, ready unchanged", 64'(cmdRdData), 64'h20AB_1234);
    check("R11 no MDC activity", 64'(edgeCnt), 64'd0);
    for (int p = 0; p < 32; p++) begin
      runTxn(p[0], 5'(p), 5'(31 - p), 16'(p * 16'h0B3D + 7), p[1],
             p == 5 || p == 12, p == 9);
    end
    edgeCnt = 0;
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = 32'h00AB_1234;
    @(negedge clk); cmdWrEn = 1'b0;
    repeat (20) @(negedge clk);
    check("R11 ready kept after no-op store", 64'(cmdRdData), 64'h10AB_1234);
    check("R11 no MDC activity after no-op store", 64'(edgeCnt), 64'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule